// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of a small, direct-mapped set of cache lines for one processor on a shared snooping bus. Each line has a stored tag and a two-bit state: Invalid, Shared, Exclusive (clean, sole copy) or Modified (dirty, sole copy). Local processor reads and writes are looked up by line address. A request that needs the bus raises a bus request and stalls the processor until the bus reports completion. Events snooped from other processors (a read, or an intent to write) are looked up in the same tag store and can downgrade or invalidate a line. A writeback is requested whenever dirty data must leave the cache.

Addresses are line addresses with no byte offset. The low `IDX_W` bits select the line and the remaining bits form the tag. The Exclusive state lets a processor that read a line no other cache holds write it later without any bus traffic. A probe port returns the current state of any line address, so the surrounding logic can see the updated line state. The data array, the bus arbiter and memory lie outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. The probe returns 0 for any address and no snoop reports a hit.
- R2: A local read miss raises a bus request of kind 1 (read) from the cycle after acceptance until `busDone`. On completion the line becomes Shared (state 1) if `busShared` is 1, or Exclusive (state 2) if it is 0, and `cpuReady` is high in the completion cycle.
- R3: A local write that hits an Exclusive line completes in its first cycle with `cpuReady` high, raises no bus request, and leaves the line Modified (state 3).
- R4: A local write miss issues bus kind 2 (read-for-ownership), and a local write to a Shared line issues bus kind 3 (upgrade). Both end in Modified. While a request waits, its kind and address stay unchanged.
- R5: A snooped intent-to-write (`snoopItw` = 1) that hits a line makes it Invalid. If the line was Modified, `wbReq` is high in that cycle with `wbAddr` equal to the snooped address.
- R6: A snooped read (`snoopItw` = 0) that hits a Modified line raises `wbReq` with the snooped address and leaves the line Shared. A snooped read of an Exclusive line leaves it Shared with no writeback, and a Shared line stays Shared.
- R7: Local reads and writes that hit Modified, and local reads that hit Shared or Exclusive, complete in their first cycle with no bus request and no state change.
- R8: When `snoopValid` and `cpuValid` are both high, the snoop is handled and the local request is stalled (`cpuReady` low) with no effect on line state.
- R9: `snoopHit` is high only when the snooped tag matches a line whose state is not Invalid. A snoop that misses leaves every line unchanged.
- R10: A miss whose index holds a Modified line with a different tag raises `wbReq` in the acceptance cycle with the victim's address, and the victim becomes Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Local request present, held until cpuReady |
| cpuWrite | input | 1 | 1 = local write, 0 = local read |
| cpuAddr | input | LA_W | Local line address |
| cpuReady | output | 1 | Local request completes this cycle |
| snoopValid | input | 1 | Snooped bus event present |
| snoopItw | input | 1 | 1 = intent to write, 0 = read |
| snoopAddr | input | LA_W | Snooped line address |
| snoopHit | output | 1 | Snooped line is held in a valid state |
| busReqValid | output | 1 | Bus request outstanding |
| busReqKind | output | 2 | 1 read, 2 read-for-ownership, 3 upgrade |
| busReqAddr | output | LA_W | Line address of the bus request |
| busDone | input | 1 | Bus request completes this cycle |
| busShared | input | 1 | Another cache holds the line (sampled with busDone) |
| wbReq | output | 1 | Write back a dirty line this cycle |
| wbAddr | output | LA_W | Line address to write back |
| probeAddr | input | LA_W | Line address to query |
| probeState | output | 2 | State of probeAddr: 0 I, 1 S, 2 E, 3 M |

## Verification
On every cycle the embedded properties check four things. Snooped invalidations and snooped reads leave the indexed line Invalid or Shared. A miss always leads to a bus request, and that request stays stable until completion. A write hit on an Exclusive line never reaches the bus, and a snoop stalls any local request. Only the bench scenarios can show the complete transition table, by sweeping every starting state against every local and snooped event on every line index. The same applies to the Shared-or-Exclusive choice made by the shared response, victim writebacks on conflict misses, and the resumption of a stalled write after the snoop that downgraded its line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RFO  = 2'd2,
    BUS_UPG  = 2'd3
  } busKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       setEn;      // write state/tag of one line
    logic       setUseReq;  // take the line address from the latched request
    lineState_t setState;
    logic       evictWb;    // dirty victim leaves on this cycle
  } ctrlStrb_t;

  // lookup summary from datapath to control
  typedef struct packed {
    logic       hit;
    lineState_t state;
    logic       victimDirty;
  } lookup_t;

endpackage

// File: rtl/mesi_dpath.sv
module mesi_dpath
  import mesi_pkg::*;
#(
  parameter int LA_W  = 8,
  parameter int IDX_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LA_W-1:0] cpuAddr,
  input  logic [LA_W-1:0] reqAddr,
  input  logic            snoopValid,
  input  logic            snoopItw,
  input  logic [LA_W-1:0] snoopAddr,
  input  ctrlStrb_t       strb,
  output lookup_t         look,
  output logic            snoopHit,
  output logic            wbReq,
  output logic [LA_W-1:0] wbAddr,
  input  logic [LA_W-1:0] probeAddr,
  output lineState_t      probeState
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = LA_W - IDX_W;

  logic [TAG_W-1:0] tagQ   [LINES];
  lineState_t       stQ    [LINES];
  logic [TAG_W-1:0] baseTag[LINES];
  lineState_t       baseSt [LINES];
  lineState_t       nxtSt  [LINES];

  logic [LA_W-1:0]  setAddr;
  logic [IDX_W-1:0] setIdx, snIdx, cpuIdx, prIdx;
  logic [TAG_W-1:0] setTag, snTag, cpuTag, prTag;
  lineState_t       snBaseSt, snNewSt;
  logic             snDirty;

  assign setAddr = strb.setUseReq ? reqAddr : cpuAddr;
  assign setIdx  = setAddr[IDX_W-1:0];
  assign setTag  = setAddr[LA_W-1:IDX_W];
  assign snIdx   = snoopAddr[IDX_W-1:0];
  assign snTag   = snoopAddr[LA_W-1:IDX_W];
  assign cpuIdx  = cpuAddr[IDX_W-1:0];
  assign cpuTag  = cpuAddr[LA_W-1:IDX_W];
  assign prIdx   = probeAddr[IDX_W-1:0];
  assign prTag   = probeAddr[LA_W-1:IDX_W];

  // local update first, snoop effect applied on top of it
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      if (strb.setEn && (setIdx == IDX_W'(i))) begin
        baseTag[i] = setTag;
        baseSt[i]  = strb.setState;
      end else begin
        baseTag[i] = tagQ[i];
        baseSt[i]  = stQ[i];
      end
    end
  end

  assign snBaseSt = baseSt[snIdx];
  assign snoopHit = snoopValid && (snBaseSt != ST_INV) && (baseTag[snIdx] == snTag);
  assign snDirty  = snoopHit && (snBaseSt == ST_MOD);
  assign snNewSt  = snoopItw ? ST_INV : ST_SHR;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      nxtSt[i] = (snoopHit && (snIdx == IDX_W'(i))) ? snNewSt : baseSt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tagQ[i] <= '0;
        stQ[i]  <= ST_INV;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        tagQ[i] <= baseTag[i];
        stQ[i]  <= nxtSt[i];
      end
    end
  end

  assign wbReq  = snDirty || strb.evictWb;
  assign wbAddr = snDirty ? snoopAddr : {tagQ[cpuIdx], cpuIdx};

  assign look.hit         = (stQ[cpuIdx] != ST_INV) && (tagQ[cpuIdx] == cpuTag);
  assign look.state       = stQ[cpuIdx];
  assign look.victimDirty = (stQ[cpuIdx] == ST_MOD) && (tagQ[cpuIdx] != cpuTag);

  assign probeState = (tagQ[prIdx] == prTag) ? stQ[prIdx] : ST_INV;

  p_itw_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoopValid && snoopItw && snoopHit) |=> (stQ[$past(snIdx)] == ST_INV));

  p_rd_shares_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoopValid && !snoopItw && snoopHit) |=> (stQ[$past(snIdx)] == ST_SHR));

  p_inv_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snoopValid && (probeAddr == snoopAddr) && (probeState == ST_INV) && !strb.setEn)
      |-> !snoopHit);

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int LA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpuValid,
  input  logic            cpuWrite,
  input  logic [LA_W-1:0] cpuAddr,
  input  logic            snoopValid,
  input  logic            busDone,
  input  logic            busShared,
  input  lookup_t         look,
  output ctrlStrb_t       strb,
  output logic            cpuReady,
  output logic            busReqValid,
  output busKind_t        busReqKind,
  output logic [LA_W-1:0] busReqAddr
);

  typedef enum logic {C_IDLE, C_BUSY} ctrlSt_t;

  ctrlSt_t         fsmQ, fsmD;
  busKind_t        kindQ, kindD;
  logic [LA_W-1:0] addrQ;
  logic            loadReq;
  logic            accept;

  assign accept = (fsmQ == C_IDLE) && cpuValid && !snoopValid;

  always_comb begin
    strb     = '0;
    cpuReady = 1'b0;
    fsmD     = fsmQ;
    kindD    = kindQ;
    loadReq  = 1'b0;
    case (fsmQ)
      C_IDLE: begin
        if (accept) begin
          if (look.hit) begin
            if (!cpuWrite || (look.state == ST_MOD)) begin
              cpuReady = 1'b1;
            end else if (look.state == ST_EXC) begin
              cpuReady      = 1'b1;
              strb.setEn    = 1'b1;
              strb.setState = ST_MOD;
            end else begin
              fsmD    = C_BUSY;
              kindD   = BUS_UPG;
              loadReq = 1'b1;
            end
          end else begin
            strb.evictWb  = look.victimDirty;
            strb.setEn    = 1'b1;
            strb.setState = ST_INV;
            fsmD          = C_BUSY;
            kindD         = cpuWrite ? BUS_RFO : BUS_RD;
            loadReq       = 1'b1;
          end
        end
      end
      default: begin
        if (busDone) begin
          cpuReady       = 1'b1;
          strb.setEn     = 1'b1;
          strb.setUseReq = 1'b1;
          if (kindQ == BUS_RD) strb.setState = busShared ? ST_SHR : ST_EXC;
          else                 strb.setState = ST_MOD;
          fsmD  = C_IDLE;
          kindD = BUS_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsmQ  <= C_IDLE;
      kindQ <= BUS_NONE;
      addrQ <= '0;
    end else begin
      fsmQ  <= fsmD;
      kindQ <= kindD;
      if (loadReq) addrQ <= cpuAddr;
    end
  end

  assign busReqValid = (fsmQ == C_BUSY);
  assign busReqKind  = kindQ;
  assign busReqAddr  = addrQ;

  p_silent_upgrade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpuWrite && look.hit && (look.state == ST_EXC)) |=> !busReqValid);

  p_snoop_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoopValid && cpuValid && !busReqValid) |-> !cpuReady);

  p_miss_goes_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !look.hit) |=> busReqValid);

  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busReqValid && !busDone) |=> (busReqValid && $stable(busReqAddr) && $stable(busReqKind)));

  p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid |-> (busReqKind != BUS_NONE));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LA_W  = 8,
  parameter int IDX_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpuValid,
  input  logic            cpuWrite,
  input  logic [LA_W-1:0] cpuAddr,
  output logic            cpuReady,
  input  logic            snoopValid,
  input  logic            snoopItw,
  input  logic [LA_W-1:0] snoopAddr,
  output logic            snoopHit,
  output logic            busReqValid,
  output logic [1:0]      busReqKind,
  output logic [LA_W-1:0] busReqAddr,
  input  logic            busDone,
  input  logic            busShared,
  output logic            wbReq,
  output logic [LA_W-1:0] wbAddr,
  input  logic [LA_W-1:0] probeAddr,
  output logic [1:0]      probeState
);

  ctrlStrb_t  strb;
  lookup_t    look;
  busKind_t   kind;
  lineState_t prSt;

  mesi_ctrl #(.LA_W(LA_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpuValid   (cpuValid),
    .cpuWrite   (cpuWrite),
    .cpuAddr    (cpuAddr),
    .snoopValid (snoopValid),
    .busDone    (busDone),
    .busShared  (busShared),
    .look       (look),
    .strb       (strb),
    .cpuReady   (cpuReady),
    .busReqValid(busReqValid),
    .busReqKind (kind),
    .busReqAddr (busReqAddr)
  );

  mesi_dpath #(.LA_W(LA_W), .IDX_W(IDX_W)) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpuAddr    (cpuAddr),
    .reqAddr    (busReqAddr),
    .snoopValid (snoopValid),
    .snoopItw   (snoopItw),
    .snoopAddr  (snoopAddr),
    .strb       (strb),
    .look       (look),
    .snoopHit   (snoopHit),
    .wbReq      (wbReq),
    .wbAddr     (wbAddr),
    .probeAddr  (probeAddr),
    .probeState (prSt)
  );

  assign busReqKind = kind;
  assign probeState = prSt;

endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LA_W  = 8;
  localparam int IDX_W = 2;
  localparam int LINES = 1 << IDX_W;

  localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3;
  localparam int K_NONE = 0, K_RD = 1, K_RFO = 2, K_UPG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuValid = 0, cpuWrite = 0, snoopValid = 0, snoopItw = 0;
  logic busDone = 0, busShared = 0;
  logic [LA_W-1:0] cpuAddr = '0, snoopAddr = '0, probeAddr = '0;
  logic cpuReady, snoopHit, busReqValid, wbReq;
  logic [1:0] busReqKind, probeState;
  logic [LA_W-1:0] busReqAddr, wbAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.LA_W(LA_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuReady(cpuReady),
    .snoopValid(snoopValid), .snoopItw(snoopItw), .snoopAddr(snoopAddr), .snoopHit(snoopHit),
    .busReqValid(busReqValid), .busReqKind(busReqKind), .busReqAddr(busReqAddr),
    .busDone(busDone), .busShared(busShared),
    .wbReq(wbReq), .wbAddr(wbAddr),
    .probeAddr(probeAddr), .probeState(probeState)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic probe(logic [LA_W-1:0] a, int exp, string req);
    probeAddr = a;
    #1;
    check(probeState == exp, req, "probeState", probeState, exp);
  endtask

  task automatic localOp(bit wr, logic [LA_W-1:0] a, int expKind, bit shr,
                         bit expWb, logic [LA_W-1:0] expWbAddr, string req);
    @(negedge clk);
    cpuValid = 1; cpuWrite = wr; cpuAddr = a;
    #1;
    check(wbReq == expWb, req, "wbReq at accept", wbReq, expWb);
    if (expWb) check(wbAddr == expWbAddr, req, "victim wbAddr", wbAddr, expWbAddr);
    if (expKind == K_NONE) begin
      check(cpuReady == 1, req, "cpuReady on hit", cpuReady, 1);
      @(negedge clk);
      cpuValid = 0;
      #1;
      check(busReqValid == 0, req, "no bus request", busReqValid, 0);
    end else begin
      check(cpuReady == 0, req, "stall on bus op", cpuReady, 0);
      @(negedge clk);
      #1;
      check(busReqValid == 1, req, "busReqValid", busReqValid, 1);
      check(busReqKind == expKind, req, "busReqKind", busReqKind, expKind);
      check(busReqAddr == a, req, "busReqAddr", busReqAddr, a);
      busDone = 1; busShared = shr;
      #1;
      check(cpuReady == 1, req, "cpuReady at completion", cpuReady, 1);
      @(negedge clk);
      busDone = 0; busShared = 0; cpuValid = 0;
    end
  endtask

  task automatic snoopOp(bit itw, logic [LA_W-1:0] a, bit expHit, bit expWb, string req);
    @(negedge clk);
    snoopValid = 1; snoopItw = itw; snoopAddr = a;
    #1;
    check(snoopHit == expHit, req, "snoopHit", snoopHit, expHit);
    check(wbReq == expWb, req, "snoop wbReq", wbReq, expWb);
    if (expWb) check(wbAddr == a, req, "snoop wbAddr", wbAddr, a);
    @(negedge clk);
    snoopValid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [LA_W-1:0] a, vA, vB;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int i = 0; i < LINES; i++) probe(LA_W'(i), S_I, "R1");
    snoopOp(0, 8'h00, 0, 0, "R1");

    // sweep: every line, every start state, every event
    for (int idx = 0; idx < LINES; idx++) begin
      for (int st = 0; st < 4; st++) begin
        for (int ev = 0; ev < 4; ev++) begin
          int expKind, nxt;
          bit shr, hit, wb;
          string req;
          a = {6'(5 + idx), 2'(idx)};
          // clear to Invalid using the current model
          probeAddr = a; #1;
          snoopOp(1, a, probeState != S_I, probeState == S_M, "R5");
          if (st == S_S) localOp(0, a, K_RD, 1, 0, '0, "R2");
          else if (st == S_E) localOp(0, a, K_RD, 0, 0, '0, "R2");
          else if (st == S_M) localOp(1, a, K_RFO, 0, 0, '0, "R4");
          probe(a, st, "R2");
          shr = idx[0];
          hit = (st != S_I);
          wb  = (st == S_M);
          case (ev)
            0: begin
              expKind = (st == S_I) ? K_RD : K_NONE;
              nxt = (st == S_I) ? (shr ? S_S : S_E) : st;
              req = (st == S_I) ? "R2" : "R7";
              localOp(0, a, expKind, shr, 0, '0, req);
            end
            1: begin
              expKind = (st == S_I) ? K_RFO : (st == S_S) ? K_UPG : K_NONE;
              nxt = S_M;
              req = (st == S_E) ? "R3" : (st == S_M) ? "R7" : "R4";
              localOp(1, a, expKind, 0, 0, '0, req);
            end
            2: begin
              nxt = hit ? S_S : S_I;
              snoopOp(0, a, hit, wb, hit ? "R6" : "R9");
              req = "R6";
            end
            default: begin
              nxt = S_I;
              snoopOp(1, a, hit, wb, hit ? "R5" : "R9");
              req = "R5";
            end
          endcase
          probe(a, nxt, req);
        end
      end
    end

    // R10: conflict miss with dirty victim
    vA = {6'h2A, 2'd1};
    vB = {6'h11, 2'd1};
    probeAddr = vA; #1;
    if (probeState != S_I) snoopOp(1, vA, 1, probeState == S_M, "R5");
    probeAddr = {6'(6), 2'd1}; #1;
    if (probeState != S_I) snoopOp(1, {6'(6), 2'd1}, 1, probeState == S_M, "R5");
    localOp(1, vA, K_RFO, 0, 0, '0, "R4");
    localOp(0, vB, K_RD, 0, 1, vA, "R10");
    probe(vA, S_I, "R10");
    probe(vB, S_E, "R10");

    // R9: tag mismatch on a valid index does not hit or disturb
    snoopOp(1, vA, 0, 0, "R9");
    probe(vB, S_E, "R9");

    // R8: snoop wins over a same-cycle local write to an Exclusive line
    a = {6'h33, 2'd2};
    probeAddr = {6'(7), 2'd2}; #1;
    if (probeState != S_I) snoopOp(1, {6'(7), 2'd2}, 1, probeState == S_M, "R5");
    localOp(0, a, K_RD, 0, 0, '0, "R2");
    @(negedge clk);
    cpuValid = 1; cpuWrite = 1; cpuAddr = a;
    snoopValid = 1; snoopItw = 0; snoopAddr = a;
    #1;
    check(cpuReady == 0, "R8", "cpuReady under snoop", cpuReady, 0);
    check(snoopHit == 1, "R8", "snoopHit", snoopHit, 1);
    @(negedge clk);
    snoopValid = 0;
    probeAddr = a;
    #1;
    check(probeState == S_S, "R8", "state after snoop, local write held", probeState, S_S);
    check(cpuReady == 0, "R8", "resumed write needs upgrade", cpuReady, 0);
    @(negedge clk);
    #1;
    check(busReqValid == 1, "R4", "upgrade request", busReqValid, 1);
    check(busReqKind == K_UPG, "R4", "upgrade kind", busReqKind, K_UPG);
    busDone = 1;
    #1;
    check(cpuReady == 1, "R4", "upgrade completes", cpuReady, 1);
    @(negedge clk);
    busDone = 0; cpuValid = 0;
    probe(a, S_M, "R4");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule